// File: doc/BRIEF.md
# Block Write-Protect Guard

This block rules on every nonvolatile write request aimed at a 4096-byte array. It keeps a four-bit protection register at the topmost array address. The register holds a write-enable latch, a two-bit protected-region selector and a hardware-lock enable. Each request carries a target address and, for register writes, new register data. One cycle later the block answers with a single-cycle allow pulse or a single-cycle reject pulse. It also shows the register contents at all times. A serial front end and the array controller are expected to sit around it. The register value after reset is a parameter, standing in for the stored nonvolatile setting.

Protection comes in three layers. The software latch must be set before any array write is accepted. The selector protects a region counted down from the top address. When the write-protect pin is high and the hardware-lock enable is set, the selector and the lock enable are frozen. Only the latch bit can still change.

Top module: `wp_guard`

## Requirements
- R1: While reset is low at a clock edge, the register takes the value of `PROT_INIT` (default 0) and both `wr_allow` and `wr_reject` are low after that edge.
- R2: Each cycle with `wr_req` high produces exactly one one-cycle pulse, on either `wr_allow` or `wr_reject`, in the next cycle. A cycle without `wr_req` produces neither pulse.
- R3: While the latch (`prot_q[0]`) is 0, every array write (any address other than 0xFFF) is rejected.
- R4: Selector `prot_q[2:1]`: 00 protects nothing, 01 protects 0xC00–0xFFF, 10 protects 0x800–0xFFF and 11 protects the whole array. An array write to a protected address is rejected.
- R5: A write to address 0xFFF targets the register. If accepted, `wr_data` loads `prot_q` bit for bit (bit 0 latch, bits 2:1 selector, bit 3 lock enable), and the new value is visible one cycle after the request. Register writes are not subject to the region selector.
- R6: While `wp_pin` is low, the lock enable has no effect. A register write is accepted if the latch is 1, or if it leaves bits 3:1 unchanged.
- R7: While `wp_pin` is high and `prot_q[3]` is 1, a register write that would change bits 3:1 is rejected. A write that changes only the latch is accepted.
- R8: While `wp_pin` is high and `prot_q[3]` is 0, the register can be written normally. Once the lock enable is set this way, the fields can no longer be cleared while the pin stays high.
- R9: A rejected write, or any request to an address other than 0xFFF, leaves `prot_q` unchanged.
- R10: An address one below the protected region (0xBFF for selector 01, 0x7FF for selector 10) is accepted when the latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Write request strobe, one cycle per request |
| wr_addr | input | 12 | Target array address; 0xFFF is the protection register |
| wr_data | input | 4 | New register value for writes to 0xFFF |
| wp_pin | input | 1 | Write-protect pin level |
| wr_allow | output | 1 | One-cycle pulse: the request is accepted |
| wr_reject | output | 1 | One-cycle pulse: the request is refused |
| prot_q | output | 4 | Current protection register contents |

## Verification
The hardest state to reach is the hardware lock. Getting there needs an ordered climb from reset: set the latch with a fields-unchanged write, program a selector, raise the pin, and only then set the lock enable. After that the stimulus tries every kind of field change under the lock, clears and resets the latch alone, and drops the pin to show the freeze lifts. Boundary addresses on each side of the quarter and half regions are hit under every selector value. A random tail then mixes pin toggles, register rewrites and biased addresses, all checked against the bench model on every clock.

// File: rtl/wp_guard_pkg.sv
`timescale 1ns/1ps
// Shared types for the write-protect guard.
// Assumes the register layout is fixed: lock enable at the top, latch at bit 0.
package wp_guard_pkg;

    // Protected-region selector values; the encoding is decoded by wp_region_dec.
    typedef enum logic [1:0] {
        BLK_NONE = 2'b00,
        BLK_QTR  = 2'b01,
        BLK_HALF = 2'b10,
        BLK_ALL  = 2'b11
    } blk_sel_e;

    // Protection register: bit 3 lock enable, bits 2:1 selector, bit 0 latch.
    typedef struct packed {
        logic     lock_en;
        blk_sel_e sel;
        logic     latch;
    } prot_reg_t;

    localparam int PROT_W = $bits(prot_reg_t);

endpackage

// File: rtl/wp_region_dec.sv
`timescale 1ns/1ps
// Region decoder: flags whether an address lies inside the protected region.
// Assumes ADDR_W >= 2 and that regions are counted down from the top address.
module wp_region_dec
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  blk_sel_e          sel,
    output logic              in_region
);

    localparam int MSB = ADDR_W - 1;

    logic top_quarter;
    logic top_half;

    // Upper quarter: both top address bits set; upper half: top bit set.
    assign top_quarter = addr[MSB] & addr[MSB-1];
    assign top_half    = addr[MSB];

    // Select the region test named by the selector.
    always_comb begin
        unique case (sel)
            BLK_NONE: in_region = 1'b0;
            BLK_QTR:  in_region = top_quarter;
            BLK_HALF: in_region = top_half;
            BLK_ALL:  in_region = 1'b1;
            default:  in_region = 1'b1;
        endcase
    end

endmodule

// File: rtl/wp_decide.sv
`timescale 1ns/1ps
// Policy logic: decides accept or refuse for one request, and whether to load the register.
// Assumes at most one request per cycle and that the register sits at the all-ones address.
module wp_decide
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  prot_reg_t         new_val,
    input  prot_reg_t         cur,
    input  logic              pin,
    output logic              accept,
    output logic              refuse,
    output logic              load_reg
);

    localparam logic [ADDR_W-1:0] REG_ADDR = {ADDR_W{1'b1}};

    logic is_reg;
    logic in_region;
    logic hw_lock;
    logic fields_same;
    logic reg_ok;
    logic arr_ok;

    wp_region_dec #(.ADDR_W(ADDR_W)) u_region (
        .addr      (addr),
        .sel       (cur.sel),
        .in_region (in_region)
    );

    // Classify the request and gather the protection conditions.
    always_comb begin
        is_reg      = (addr == REG_ADDR);
        hw_lock     = pin & cur.lock_en;
        fields_same = (new_val.lock_en == cur.lock_en) && (new_val.sel == cur.sel);
    end

    // Latch-only changes always pass; field changes need the latch and no hardware lock.
    always_comb begin
        reg_ok = fields_same | (cur.latch & ~hw_lock);
        arr_ok = cur.latch & ~in_region;
    end

    // Produce the verdict for this cycle's request.
    always_comb begin
        accept   = 1'b0;
        refuse   = 1'b0;
        load_reg = 1'b0;
        if (req) begin
            if (is_reg) begin
                accept   = reg_ok;
                refuse   = ~reg_ok;
                load_reg = reg_ok;
            end else begin
                accept = arr_ok;
                refuse = ~arr_ok;
            end
        end
    end

endmodule

// File: rtl/wp_prot_store.sv
`timescale 1ns/1ps
// Protection register storage; the reset value stands in for the stored nonvolatile setting.
// Assumes load is asserted only for accepted register writes.
module wp_prot_store
    import wp_guard_pkg::*;
#(
    parameter logic [PROT_W-1:0] INIT = '0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  prot_reg_t d,
    output prot_reg_t q
);

    // Hold the register; restore the initial value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= prot_reg_t'(INIT);
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/wp_guard.sv
`timescale 1ns/1ps
// Top: write-protect guard. Answers each request with a one-cycle allow or reject pulse.
// Assumes the requester holds wr_addr, wr_data and wp_pin valid in the request cycle.
module wp_guard
    import wp_guard_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [PROT_W-1:0] PROT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PROT_W-1:0] wr_data,
    input  logic              wp_pin,
    output logic              wr_allow,
    output logic              wr_reject,
    output logic [PROT_W-1:0] prot_q
);

    prot_reg_t cur_reg;
    prot_reg_t new_val;
    logic      accept;
    logic      refuse;
    logic      load_reg;

    assign new_val = prot_reg_t'(wr_data);
    assign prot_q  = cur_reg;

    wp_decide #(.ADDR_W(ADDR_W)) u_decide (
        .req      (wr_req),
        .addr     (wr_addr),
        .new_val  (new_val),
        .cur      (cur_reg),
        .pin      (wp_pin),
        .accept   (accept),
        .refuse   (refuse),
        .load_reg (load_reg)
    );

    wp_prot_store #(.INIT(PROT_INIT)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_reg),
        .d     (new_val),
        .q     (cur_reg)
    );

    // Register the verdict as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_allow  <= 1'b0;
            wr_reject <= 1'b0;
        end else begin
            wr_allow  <= accept;
            wr_reject <= refuse;
        end
    end

endmodule

// File: rtl/wp_guard_chk.sv
`timescale 1ns/1ps
// Assertion checker for wp_guard, attached by bind below.
// Assumes only the top-level ports; no internal state is observed.
module wp_guard_chk #(
    parameter int                ADDR_W    = 12,
    parameter int                PW        = 4,
    parameter logic [PW-1:0]     PROT_INIT = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wp_pin,
    input logic              wr_allow,
    input logic              wr_reject,
    input logic [PW-1:0]     prot_q
);

    localparam logic [ADDR_W-1:0] REG_ADDR = {ADDR_W{1'b1}};

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (prot_q == PROT_INIT) && !wr_allow && !wr_reject);

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> (wr_allow ^ wr_reject));

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> (!wr_allow && !wr_reject));

    // R3
    latch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_addr != REG_ADDR && !prot_q[0]) |=> wr_reject);

    // R4
    full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_addr != REG_ADDR && prot_q[2:1] == 2'b11) |=> wr_reject);

    // R7
    hw_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_addr == REG_ADDR && wp_pin && prot_q[3])
            |=> (prot_q[3:1] == $past(prot_q[3:1])));

    // R9
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && wr_addr == REG_ADDR) |=> $stable(prot_q));

    // R9
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> $stable(prot_q));

endmodule

bind wp_guard wp_guard_chk #(
    .ADDR_W    (ADDR_W),
    .PW        (wp_guard_pkg::PROT_W),
    .PROT_INIT (PROT_INIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wp_pin    (wp_pin),
    .wr_allow  (wr_allow),
    .wr_reject (wr_reject),
    .prot_q    (prot_q)
);

// File: tb/wp_guard_tb.sv
`timescale 1ns/1ps
// Bench for wp_guard: behavioural reference model compared on every clock.
module wp_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [3:0]  wr_data = '0;
    logic        wp_pin = 1'b0;
    logic        wr_allow;
    logic        wr_reject;
    logic [3:0]  prot_q;

    int    n_checks = 0;
    int    n_fail = 0;
    int    m_reg = 0;
    bit    e_allow = 0;
    bit    e_reject = 0;
    string cur_tag = "R2";

    always #2 clk = ~clk;

    wp_guard u_dut (
        .clk (clk), .rst_n (rst_n), .wr_req (wr_req), .wr_addr (wr_addr),
        .wr_data (wr_data), .wp_pin (wp_pin), .wr_allow (wr_allow),
        .wr_reject (wr_reject), .prot_q (prot_q)
    );

    // Reference: is an address inside the region named by the selector?
    function automatic bit protected_addr(int a, int sel);
        case (sel)
            0: return 0;
            1: return a >= 'hC00;
            2: return a >= 'h800;
            default: return 1;
        endcase
    endfunction

    task automatic compare(string tag);
        n_checks++;
        if (wr_allow !== e_allow || wr_reject !== e_reject || prot_q !== 4'(m_reg)) begin
            n_fail++;
            $display("FAIL %s: allow/reject/reg actual %b/%b/%h expected %b/%b/%h",
                     tag, wr_allow, wr_reject, prot_q, e_allow, e_reject, 4'(m_reg));
        end
    endtask

    // Check the previous request's outcome, then drive a new one and update the model.
    task automatic step(bit req, int a, int d, bit pin, string tag);
        bit ok;
        @(negedge clk);
        compare(cur_tag);
        wr_req = req; wr_addr = 12'(a); wr_data = 4'(d); wp_pin = pin;
        cur_tag = tag;
        e_allow = 0; e_reject = 0;
        if (req) begin
            if (a == 'hFFF) begin
                ok = ((d & 'hE) == (m_reg & 'hE)) ||
                     ((m_reg & 1) && !(pin && (m_reg & 8)));
                if (ok) m_reg = d;
            end else begin
                ok = (m_reg & 1) && !protected_addr(a, (m_reg >> 1) & 3);
            end
            e_allow = ok; e_reject = !ok;
        end
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual run still active expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1");                       // R1 reset state
        rst_n = 1'b1;
        step(1, 'h010, 0, 0, "R3");          // array write with latch clear
        step(1, 'hFFF, 'hF, 0, "R3");        // field change with latch clear
        step(1, 'hFFF, 'h1, 0, "R5");        // latch-only set
        step(1, 'h010, 0, 0, "R2");
        step(0, 0, 0, 0, "R2");              // idle: no pulse
        step(1, 'hFFF, 'h3, 0, "R5");        // selector 01
        step(1, 'hBFF, 0, 0, "R10");
        step(1, 'hC00, 0, 0, "R4");
        step(1, 'hFFE, 0, 0, "R4");
        step(1, 'hFFF, 'h5, 0, "R5");        // selector 10
        step(1, 'h7FF, 0, 0, "R10");
        step(1, 'h800, 0, 0, "R4");
        step(1, 'hFFF, 'h7, 0, "R5");        // selector 11
        step(1, 'h000, 0, 0, "R4");
        step(1, 'hFFF, 'h1, 0, "R5");        // selector 00
        step(1, 'hFFE, 0, 0, "R4");
        step(1, 'hFFF, 'h9, 1, "R8");        // set lock with pin high
        step(1, 'hFFF, 'hB, 1, "R7");        // selector change refused
        step(1, 'hFFF, 'h0, 1, "R7");        // lock clear refused
        step(1, 'hFFF, 'h8, 1, "R7");        // latch-only clear accepted
        step(1, 'h100, 0, 1, "R3");
        step(1, 'hFFF, 'h9, 1, "R7");        // latch-only set accepted
        step(1, 'hFFF, 'hB, 0, "R6");        // pin low: fields writable
        step(1, 'hFFF, 'h3, 0, "R6");        // pin low: lock cleared
        step(1, 'hFFF, 'h7, 1, "R8");        // pin high, lock clear: writable
        step(0, 0, 0, 1, "R9");
        for (int i = 0; i < 600; i++) begin
            int a;
            int pick = $urandom % 6;
            a = (pick == 0) ? 'hFFF : (pick == 1) ? 'hBFF : (pick == 2) ? 'hC00 :
                (pick == 3) ? 'h7FF : (pick == 4) ? 'h800 : int'($urandom % 4096);
            step(($urandom % 4) != 0, a, $urandom % 16, ($urandom % 3) == 0, "R9");
        end
        step(0, 0, 0, 0, "R2");
        @(negedge clk);
        compare(cur_tag);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule